// File: doc/BRIEF.md
# I2C Register-Map Target

This block is an I2C target that gives a controller access to a bank of byte-wide registers. It samples SCL and SDA from open-drain pads with the system clock and only ever pulls SDA low. It pulls SDA low to acknowledge received bytes and to send the zero bits of read data. The 7-bit target address has six fixed upper bits. Its lowest bit follows a strap input, so two targets can share one bus.

A write transfer sends the address byte and then a pointer byte. The pointer byte carries a step flag in bit 7 and a 7-bit register index in bits 6..0. Every later byte of that transfer is stored in the register the pointer selects. A read transfer has no pointer phase of its own. It returns bytes starting at the register the pointer currently selects. A controller therefore sets the pointer with a write that it ends straight after the pointer byte, and then issues the read. When the step flag is set, the pointer advances after every data byte, in either direction of transfer.

The system clock must run at least eight times faster than SCL. Clock stretching, 10-bit addressing and general call are not supported.

Top module: `i2c_regmap_target`

## Requirements
- R1: After reset, and while no transfer addressed to the target is running, SDA is released (`sda_oe_o` = 0).
- R2: The target acknowledges an address byte whose seven address bits, sent MSB first, are 1,0,0,1,1,1 followed by the level of `ad0_i`. Any other address gets no acknowledge, and the target ignores the bus until the next Start or Stop.
- R3: The acknowledge is SDA held low through the ninth SCL pulse after each byte the target receives.
- R4: In a write transfer (R/W bit, the eighth bit of the address byte, equal to 0), the byte after the address byte sets the pointer: bit 7 is the step flag and bits 6..0 are the register index. Every later data byte is written to the register the pointer selects.
- R5: In a read transfer (R/W bit = 1), the target sends the selected register MSB first, pulling SDA low only for 0 bits.
- R6: With the step flag set, the pointer advances by one after each data byte written or read, and wraps from 127 to 0.
- R7: With the step flag clear, the pointer stays where it is. Successive writes overwrite one register, successive reads repeat one register, and neighbouring registers are not touched.
- R8: A Stop or a repeated Start right after the pointer byte's acknowledge writes no register and keeps the pointer for the next read.
- R9: A NACK from the controller after a read byte makes the target release SDA and send nothing more until the next Start.
- R10: A Start is SDA falling while SCL is high, and a Stop is SDA rising while SCL is high. Either one aborts a byte in progress without writing it. A Start always begins a new address phase, and SDA is released at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, at least 8x the SCL rate |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | SCL level from the pad |
| sda_i | input | 1 | SDA level from the pad |
| ad0_i | input | 1 | Strap input that sets the lowest address bit |
| sda_oe_o | output | 1 | 1 pulls SDA low, 0 releases it |

## Verification
Storing a received data byte and stepping the pointer happen on the same clock edge. A stepped burst that starts at register 100 and crosses the 127-to-0 wrap provokes this overlap on every byte. The result is judged by reading the whole bank back and comparing each byte with a value computed from its index. The other overlap is a Start or Stop that lands in the middle of a byte. The bench forces it by cutting off address and data bytes partway through. It then checks that the next address phase is acknowledged, and that the register the cut-off byte pointed at still holds its old value.

// File: rtl/i2c_regmap_pkg.sv
package i2c_regmap_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned PTR_W  = 7;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_ACK,
    ST_TX,
    ST_TX_ACK,
    ST_IGNORE
  } tgt_state_e;

  typedef enum logic [1:0] {
    RX_ADDR,
    RX_PTR,
    RX_DATA
  } rx_kind_e;
endpackage

// File: rtl/i2c_bus_sync.sv
module i2c_bus_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES-1:0] scl_q, sda_q;
  logic              scl_d, sda_d;

  // idle bus is high, so reset the chain high
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= '1;
      sda_q <= '1;
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_q <= {scl_q[STAGES-2:0], scl_i};
      sda_q <= {sda_q[STAGES-2:0], sda_i};
      scl_d <= scl_o;
      sda_d <= sda_o;
    end
  end

  assign scl_o      = scl_q[STAGES-1];
  assign sda_o      = sda_q[STAGES-1];
  assign scl_rise_o = scl_o & ~scl_d;
  assign scl_fall_o = ~scl_o & scl_d;
  assign start_o    = scl_o & scl_d & sda_d & ~sda_o;
  assign stop_o     = scl_o & scl_d & ~sda_d & sda_o;
endmodule

// File: rtl/i2c_reg_array.sv
module i2c_reg_array #(
  parameter int unsigned DEPTH = 128,
  parameter int unsigned DW    = 8,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] mem [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                              mem[g] <= '0;
      else if (we_i && waddr_i == AW'(g))       mem[g] <= wdata_i;
    end
  end

  assign rdata_o = mem[raddr_i];
endmodule

// File: rtl/i2c_target_fsm.sv
module i2c_target_fsm
  import i2c_regmap_pkg::*;
#(
  parameter logic [5:0] ADDR_HIGH = 6'b100111
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_s_i,
  input  logic              sda_s_i,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              ad0_i,
  output logic              sda_oe_o,
  output logic              reg_we_o,
  output logic [PTR_W-1:0]  reg_waddr_o,
  output logic [BYTE_W-1:0] reg_wdata_o,
  output logic [PTR_W-1:0]  reg_raddr_o,
  input  logic [BYTE_W-1:0] reg_rdata_i
);
  tgt_state_e        state;
  rx_kind_e          rx_kind;
  logic [2:0]        bit_cnt;
  logic [BYTE_W-1:0] shreg;
  logic              byte_full;
  logic              rd_mode;
  logic              step_en;
  logic [PTR_W-1:0]  ptr;
  logic              ctrl_ack;

  assign reg_we_o    = (state == ST_RX) && (rx_kind == RX_DATA) && byte_full && scl_fall_i;
  assign reg_waddr_o = ptr;
  assign reg_wdata_o = shreg;
  assign reg_raddr_o = ptr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state     <= ST_IDLE;
      rx_kind   <= RX_ADDR;
      bit_cnt   <= '0;
      shreg     <= '0;
      byte_full <= 1'b0;
      rd_mode   <= 1'b0;
      step_en   <= 1'b0;
      ptr       <= '0;
      ctrl_ack  <= 1'b0;
      sda_oe_o  <= 1'b0;
    end else if (start_i) begin
      state     <= ST_RX;
      rx_kind   <= RX_ADDR;
      bit_cnt   <= '0;
      byte_full <= 1'b0;
      sda_oe_o  <= 1'b0;
    end else if (stop_i) begin
      state     <= ST_IDLE;
      byte_full <= 1'b0;
      sda_oe_o  <= 1'b0;
    end else begin
      unique case (state)
        ST_RX: begin
          if (scl_rise_i && !byte_full) begin
            shreg <= {shreg[BYTE_W-2:0], sda_s_i};
            if (bit_cnt == 3'd7) byte_full <= 1'b1;
            else                 bit_cnt   <= bit_cnt + 3'd1;
          end else if (scl_fall_i && byte_full) begin
            byte_full <= 1'b0;
            bit_cnt   <= '0;
            unique case (rx_kind)
              RX_ADDR: begin
                if (shreg[7:1] == {ADDR_HIGH, ad0_i}) begin
                  state    <= ST_ACK;
                  sda_oe_o <= 1'b1;
                  rd_mode  <= shreg[0];
                end else begin
                  state <= ST_IGNORE;
                end
              end
              RX_PTR: begin
                step_en  <= shreg[7];
                ptr      <= shreg[PTR_W-1:0];
                state    <= ST_ACK;
                sda_oe_o <= 1'b1;
              end
              default: begin
                if (step_en) ptr <= ptr + 1'b1;
                state    <= ST_ACK;
                sda_oe_o <= 1'b1;
              end
            endcase
          end
        end
        ST_ACK: begin
          if (scl_fall_i) begin
            bit_cnt <= '0;
            if (rd_mode) begin
              state    <= ST_TX;
              shreg    <= reg_rdata_i;
              sda_oe_o <= ~reg_rdata_i[7];
              if (step_en) ptr <= ptr + 1'b1;
            end else begin
              state    <= ST_RX;
              sda_oe_o <= 1'b0;
              rx_kind  <= (rx_kind == RX_ADDR) ? RX_PTR : RX_DATA;
            end
          end
        end
        ST_TX: begin
          if (scl_fall_i) begin
            if (bit_cnt == 3'd7) begin
              bit_cnt  <= '0;
              state    <= ST_TX_ACK;
              sda_oe_o <= 1'b0;
            end else begin
              bit_cnt  <= bit_cnt + 3'd1;
              shreg    <= {shreg[BYTE_W-2:0], 1'b0};
              sda_oe_o <= ~shreg[6];
            end
          end
        end
        ST_TX_ACK: begin
          if (scl_rise_i) ctrl_ack <= ~sda_s_i;
          else if (scl_fall_i) begin
            if (ctrl_ack) begin
              state    <= ST_TX;
              shreg    <= reg_rdata_i;
              sda_oe_o <= ~reg_rdata_i[7];
              if (step_en) ptr <= ptr + 1'b1;
            end else begin
              state    <= ST_IGNORE;
              sda_oe_o <= 1'b0;
            end
          end
        end
        default: ;
      endcase
    end
  end

  AST_OE_MOVES_SCL_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sda_oe_o != $past(sda_oe_o)) |-> (!$past(scl_s_i) || $past(start_i) || $past(stop_i))); // R10
  AST_START_REARMS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (state == ST_RX && rx_kind == RX_ADDR && !sda_oe_o)); // R10
  AST_ACK_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_ACK) |-> sda_oe_o); // R3
  AST_IGNORE_RELEASED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_IGNORE || state == ST_IDLE) |-> !sda_oe_o); // R9
  AST_WRITE_NOT_IN_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_o |-> !rd_mode); // R4
  AST_PTR_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_o && step_en) |=> (ptr == PTR_W'($past(ptr) + 1'b1))); // R6
  AST_PTR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_o && !step_en) |=> $stable(ptr)); // R7
endmodule

// File: rtl/i2c_regmap_target.sv
module i2c_regmap_target
  import i2c_regmap_pkg::*;
#(
  parameter logic [5:0]  ADDR_HIGH   = 6'b100111,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned REG_DEPTH   = 128
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  input  logic ad0_i,
  output logic sda_oe_o
);
  localparam int unsigned REG_AW = $clog2(REG_DEPTH);

  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic              reg_we;
  logic [PTR_W-1:0]  reg_waddr, reg_raddr;
  logic [BYTE_W-1:0] reg_wdata, reg_rdata;

  i2c_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .scl_o      (scl_s),
    .sda_o      (sda_s),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (start_det),
    .stop_o     (stop_det)
  );

  i2c_target_fsm #(.ADDR_HIGH(ADDR_HIGH)) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .scl_s_i     (scl_s),
    .sda_s_i     (sda_s),
    .scl_rise_i  (scl_rise),
    .scl_fall_i  (scl_fall),
    .start_i     (start_det),
    .stop_i      (stop_det),
    .ad0_i       (ad0_i),
    .sda_oe_o    (sda_oe_o),
    .reg_we_o    (reg_we),
    .reg_waddr_o (reg_waddr),
    .reg_wdata_o (reg_wdata),
    .reg_raddr_o (reg_raddr),
    .reg_rdata_i (reg_rdata)
  );

  i2c_reg_array #(.DEPTH(REG_DEPTH), .DW(BYTE_W)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (reg_we),
    .waddr_i (reg_waddr[REG_AW-1:0]),
    .wdata_i (reg_wdata),
    .raddr_i (reg_raddr[REG_AW-1:0]),
    .rdata_o (reg_rdata)
  );
endmodule

// File: tb/i2c_regmap_target_bench.sv
module i2c_regmap_target_bench;
  localparam int Q = 5;
  localparam logic [5:0] HI = 6'b100111;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_ctl = 1'b1;
  logic sda_ctl = 1'b1;
  logic ad0 = 1'b1;
  logic sda_oe;
  logic sda_line;
  int   total = 0;
  int   bad = 0;
  bit   done = 1'b0;

  always #10 clk = ~clk;
  assign sda_line = sda_ctl & ~sda_oe;

  i2c_regmap_target u_i2c_regmap_target (
    .clk_i    (clk),
    .rst_ni   (rst_n),
    .scl_i    (scl_ctl),
    .sda_i    (sda_line),
    .ad0_i    (ad0),
    .sda_oe_o (sda_oe)
  );

  function automatic logic [7:0] pat(input int idx);
    return 8'((idx * 37 + 11) & 255);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic wq(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_ctl = 1'b1; wq(Q);
    scl_ctl = 1'b1; wq(Q);
    sda_ctl = 1'b0; wq(Q);
    scl_ctl = 1'b0; wq(Q);
  endtask

  task automatic bus_stop();
    sda_ctl = 1'b0; wq(Q);
    scl_ctl = 1'b1; wq(Q);
    sda_ctl = 1'b1; wq(2 * Q);
  endtask

  task automatic clk_bit(input logic b, output logic r);
    sda_ctl = b;    wq(Q);
    scl_ctl = 1'b1; wq(Q);
    r = sda_line;   wq(Q);
    scl_ctl = 1'b0; wq(Q);
  endtask

  task automatic put_byte(input logic [7:0] d, output logic acked);
    logic r;
    for (int i = 7; i >= 0; i--) clk_bit(d[i], r);
    clk_bit(1'b1, r);
    acked = ~r;
  endtask

  task automatic get_byte(output logic [7:0] d, input logic give_ack);
    logic r;
    for (int i = 7; i >= 0; i--) begin
      clk_bit(1'b1, r);
      d[i] = r;
    end
    clk_bit(~give_ack, r);
  endtask

  // pointer set by write aborted after the pointer byte
  task automatic set_ptr(input logic [7:0] p);
    logic a;
    bus_start();
    put_byte({HI, 1'b1, 1'b0}, a); chk("R2 addr ack", a, 1);
    put_byte(p, a);                chk("R4 ptr ack", a, 1);
    bus_stop();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=0 exp=1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic a, r;
    logic [7:0] d;
    int ack_err;
    wq(4);
    chk("R1 reset release", sda_oe, 0);
    rst_n = 1'b1;
    wq(4);
    chk("R1 idle release", sda_oe, 0);

    // R2 address sweep with strap high
    for (int ad = 0; ad < 128; ad++) begin
      bus_start();
      put_byte({7'(ad), 1'b0}, a);
      chk("R2 sweep", a, (ad == {HI, 1'b1}) ? 1 : 0);
      bus_stop();
    end
    // R2 ignored transfer stays silent on later bytes
    bus_start();
    put_byte({HI, 1'b0, 1'b0}, a); chk("R2 wrong addr", a, 0);
    put_byte(8'h00, a);            chk("R2 ignored byte", a, 0);
    bus_stop();
    ad0 = 1'b0;
    bus_start(); put_byte({HI, 1'b0, 1'b0}, a); chk("R2 strap low match", a, 1); bus_stop();
    bus_start(); put_byte({HI, 1'b1, 1'b0}, a); chk("R2 strap low miss", a, 0); bus_stop();
    ad0 = 1'b1;

    // R4 R6 stepped burst across the wrap, store and step on one edge
    ack_err = 0;
    bus_start();
    put_byte({HI, 1'b1, 1'b0}, a); chk("R3 addr ack", a, 1);
    put_byte(8'h80 | 8'd100, a);   chk("R3 ptr ack", a, 1);
    for (int k = 0; k < 128; k++) begin
      put_byte(pat((100 + k) % 128), a);
      if (!a) ack_err++;
    end
    bus_stop();
    chk("R3 data acks", ack_err, 0);

    // R5 R6 R8 aborted write then stepped read of the whole bank
    set_ptr(8'h80 | 8'd100);
    bus_start();
    put_byte({HI, 1'b1, 1'b1}, a); chk("R2 read addr ack", a, 1);
    for (int k = 0; k < 128; k++) begin
      get_byte(d, k != 127);
      chk("R5 R6 readback", d, pat((100 + k) % 128));
    end
    bus_stop();

    // R7 fixed pointer, repeated Start into read (R8)
    bus_start();
    put_byte({HI, 1'b1, 1'b0}, a);
    put_byte(8'd5, a);
    put_byte(8'hA1, a);
    put_byte(8'hB2, a); chk("R7 second data ack", a, 1);
    bus_start();
    put_byte({HI, 1'b1, 1'b1}, a);
    for (int k = 0; k < 3; k++) begin
      get_byte(d, k != 2);
      chk("R7 same reg", d, 8'hB2);
    end
    bus_stop();
    set_ptr(8'd6);
    bus_start(); put_byte({HI, 1'b1, 1'b1}, a);
    get_byte(d, 1'b0); chk("R7 neighbour kept", d, pat(6));
    bus_stop();

    // R9 NACK ends sending, R6 read step
    set_ptr(8'h80 | 8'd10);
    bus_start(); put_byte({HI, 1'b1, 1'b1}, a);
    get_byte(d, 1'b0); chk("R5 first byte", d, pat(10));
    get_byte(d, 1'b0); chk("R9 silent after nack", d, 8'hFF);
    chk("R9 released", sda_oe, 0);
    bus_stop();
    bus_start(); put_byte({HI, 1'b1, 1'b1}, a);
    get_byte(d, 1'b0); chk("R6 read stepped", d, pat(11));
    bus_stop();

    // R10 Start cuts an address byte
    bus_start();
    for (int i = 0; i < 3; i++) clk_bit(1'b1, r);
    bus_start();
    put_byte({HI, 1'b1, 1'b0}, a); chk("R10 restart ack", a, 1);
    put_byte(8'd30, a);
    put_byte(8'h5C, a);
    bus_stop();
    set_ptr(8'd30);
    bus_start(); put_byte({HI, 1'b1, 1'b1}, a);
    get_byte(d, 1'b0); chk("R10 write after restart", d, 8'h5C);
    bus_stop();

    // R10 Stop cuts a data byte, register untouched
    bus_start();
    put_byte({HI, 1'b1, 1'b0}, a);
    put_byte(8'd20, a);
    for (int i = 0; i < 4; i++) clk_bit(1'b0, r);
    bus_stop();
    chk("R10 released on stop", sda_oe, 0);
    bus_start(); put_byte({HI, 1'b1, 1'b1}, a);
    get_byte(d, 1'b0); chk("R10 cut byte not stored", d, pat(20));
    bus_stop();

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule